// File: doc/BRIEF.md
# Ethernet Frame Pattern Engine

This block is the byte-wide data path for one Ethernet port and sits between the receive and transmit streams of a MAC. A static `gen_en` input picks one of two transmit behaviours. When it is low, every frame that arrives is sent back out of the same port, with the two 6-byte MAC address fields exchanged. When it is high, the block sends an endless run of identical fixed-format test frames.

Separately from the transmit mode, `chk_en` turns on a receive checker. The checker compares each incoming frame, byte by byte, with the frame a remote generator would deliver after a swapping peer has returned it. It keeps a sticky error flag and a saturating error count, and both can be cleared from outside. An activity output is stretched so that short bursts of traffic stay visible on a status indicator.

Frame layout, with byte 0 sent first: bytes 0–5 are the destination address, most significant byte first. Bytes 6–11 are the source address, most significant byte first. Bytes 12–13 are the length/type field, high byte first. From byte 14 on comes a payload whose k-th byte (counting from 0) is k mod 256. A frame is `14 + PAY_LEN` bytes long.

Top module: `eth_pattern_engine`

## Requirements
- R1: With `gen_en` low, every received frame of 12 or more bytes is sent on the transmit stream with the same number of bytes, and `tx_tlast` is set on its final byte only.
- R2: In loopback, transmitted bytes 0–5 equal received bytes 6–11. Transmitted bytes 6–11 equal received bytes 0–5. Every byte from 12 onward is passed through unchanged and in order.
- R3: With `gen_en` high, each transmitted frame has bytes 0–5 = `GEN_DA`, bytes 6–11 = `GEN_SA` and bytes 12–13 = `GEN_TYPE`, each field most significant byte first. Payload byte k is k mod 256. The frame is 14+`PAY_LEN` bytes long, with `tx_tlast` set on its final byte.
- R4: With `gen_en` high, `tx_tvalid` stays high on every cycle, so frames follow each other with no gap, and `rx_tready` stays high.
- R5: With `chk_en` high, each received byte at position p < 14+`PAY_LEN` is compared with the expected byte. The expected layout is that of R3 with the addresses exchanged: bytes 0–5 = `GEN_SA` and bytes 6–11 = `GEN_DA`. Each mismatch adds one to `err_count` and sets the sticky `frame_err`. Both outputs change in the cycle after the byte's handshake.
- R6: With `chk_en` high, a received frame whose length is not 14+`PAY_LEN` adds one more to `err_count` and sets `frame_err` when its last byte is accepted. A frame that is too long is compared only over its first 14+`PAY_LEN` bytes.
- R7: With `chk_en` low, received frames leave `err_count` and `frame_err` unchanged.
- R8: `err_clear` high sets `err_count` to 0 and `frame_err` to 0 in the next cycle. A clear takes priority over errors detected in the same cycle.
- R9: `err_count` saturates at 2^`CNT_W`−1 and never wraps.
- R10: `activity` goes high in the cycle after the last byte of any received or transmitted frame is accepted. It stays high for exactly `ACT_HOLD` cycles, and that window restarts on every later frame end.
- R11: While `tx_tvalid` is high and `tx_tready` is low, `tx_tdata` and `tx_tlast` hold their values. No byte is dropped or repeated under any pattern of backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | 1: pattern source drives transmit; 0: loopback with address swap |
| chk_en | input | 1 | Enables the receive checker |
| err_clear | input | 1 | Clears the error count and flag |
| rx_tdata | input | 8 | Received byte |
| rx_tvalid | input | 1 | Received byte valid |
| rx_tlast | input | 1 | Last byte of received frame |
| rx_tready | output | 1 | Block accepts received byte |
| tx_tdata | output | 8 | Transmitted byte |
| tx_tvalid | output | 1 | Transmitted byte valid |
| tx_tlast | output | 1 | Last byte of transmitted frame |
| tx_tready | input | 1 | MAC accepts transmitted byte |
| frame_err | output | 1 | Sticky error indication |
| err_count | output | CNT_W | Saturating error count |
| activity | output | 1 | Stretched frame-activity indication |

## Verification
The assertions rely on a few properties of the inputs. `gen_en` changes only while reset is held. The receive source keeps `rx_tdata` and `rx_tlast` steady while a byte waits for `rx_tready`, which is what lets the transmit-hold property cover loopback pass-through. Loopback frames are at least 12 bytes long. The bench switches modes only inside a reset pulse, never withdraws a received byte it has offered, and sends no loopback frame shorter than 12 bytes. While it does this, it drives `tx_tready` from a pseudo-random stall pattern.

// File: rtl/eth_pe_pkg.sv
// Shared constants and the frame layout function used by the generator
// and the checker. Assumes addresses are 48 bits and the type field 16 bits.
package eth_pe_pkg;
    localparam int unsigned ADDR_BYTES = 6;
    localparam int unsigned HDR_BYTES  = 14;

    // Byte at position idx of a frame with the given header; payload counts up.
    function automatic logic [7:0] frame_byte(input int unsigned idx,
                                              input logic [47:0] da,
                                              input logic [47:0] sa,
                                              input logic [15:0] lt);
        if (idx < ADDR_BYTES)
            return da[8*(ADDR_BYTES-1-idx) +: 8];
        else if (idx < 2*ADDR_BYTES)
            return sa[8*(2*ADDR_BYTES-1-idx) +: 8];
        else if (idx == 2*ADDR_BYTES)
            return lt[15:8];
        else if (idx == 2*ADDR_BYTES+1)
            return lt[7:0];
        return 8'(idx - HDR_BYTES);
    endfunction
endpackage

// File: rtl/eth_pe_gen.sv
// Pattern source: emits fixed-format frames back to back while enabled.
// Assumes en changes only while the downstream is idle or in reset.
module eth_pe_gen #(
    parameter int unsigned PAY_LEN  = 18,
    parameter logic [47:0] GEN_DA   = 48'h0211_2233_4455,
    parameter logic [47:0] GEN_SA   = 48'h02AA_BBCC_DDEE,
    parameter logic [15:0] GEN_TYPE = 16'h88B5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tready,
    output logic       tvalid,
    output logic [7:0] tdata,
    output logic       tlast
);
    import eth_pe_pkg::*;
    localparam int unsigned FRAME_LEN = HDR_BYTES + PAY_LEN;
    localparam int unsigned IW = $clog2(FRAME_LEN);

    logic [IW-1:0] idx;

    // Output byte is a pure function of the position counter.
    always_comb begin
        tvalid = en;
        tdata  = frame_byte(int'(idx), GEN_DA, GEN_SA, GEN_TYPE);
        tlast  = (idx == IW'(FRAME_LEN-1));
    end

    // Advance the position on each accepted byte, wrap at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            idx <= '0;
        else if (tready)
            idx <= tlast ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/eth_pe_swap.sv
// Loopback path: captures the 12 address bytes of each received frame,
// sends them with the two addresses exchanged, then passes the rest through.
// Assumes frames of at least 12 bytes; a shorter frame is discarded.
module eth_pe_swap (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] rx_tdata,
    input  logic       rx_tvalid,
    input  logic       rx_tlast,
    output logic       rx_tready,
    output logic [7:0] tx_tdata,
    output logic       tx_tvalid,
    output logic       tx_tlast,
    input  logic       tx_tready
);
    typedef enum logic [1:0] {S_FILL, S_HDR, S_PASS} swap_state_t;

    swap_state_t state;
    logic [7:0]  hbuf [12];
    logic [3:0]  cnt;
    logic        hdr_last;
    logic [3:0]  rd_idx;

    // Read order: source address first, then destination address.
    always_comb rd_idx = (cnt < 4'd6) ? cnt + 4'd6 : cnt - 4'd6;

    // Stream steering per phase.
    always_comb begin
        rx_tready = 1'b0;
        tx_tvalid = 1'b0;
        tx_tdata  = 8'h00;
        tx_tlast  = 1'b0;
        case (state)
            S_FILL: rx_tready = en;
            S_HDR: begin
                tx_tvalid = 1'b1;
                tx_tdata  = hbuf[rd_idx];
                tx_tlast  = (cnt == 4'd11) && hdr_last;
            end
            S_PASS: begin
                rx_tready = tx_tready;
                tx_tvalid = rx_tvalid;
                tx_tdata  = rx_tdata;
                tx_tlast  = rx_tlast;
            end
            default: ;
        endcase
    end

    // Phase sequencing and header capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state    <= S_FILL;
            cnt      <= '0;
            hdr_last <= 1'b0;
        end else begin
            case (state)
                S_FILL: if (rx_tvalid) begin
                    hbuf[cnt] <= rx_tdata;
                    if (cnt == 4'd11) begin
                        state    <= S_HDR;
                        cnt      <= '0;
                        hdr_last <= rx_tlast;
                    end else if (rx_tlast) begin
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 4'd1;
                    end
                end
                S_HDR: if (tx_tready) begin
                    if (cnt == 4'd11) begin
                        state <= hdr_last ? S_FILL : S_PASS;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 4'd1;
                    end
                end
                S_PASS: if (rx_tvalid && tx_tready && rx_tlast)
                    state <= S_FILL;
                default: state <= S_FILL;
            endcase
        end
    end
endmodule

// File: rtl/eth_pe_check.sv
// Receive checker: compares accepted bytes with the expected swapped-header
// pattern, flags length mismatches, keeps a sticky flag and saturating count.
module eth_pe_check #(
    parameter int unsigned PAY_LEN  = 18,
    parameter logic [47:0] GEN_DA   = 48'h0211_2233_4455,
    parameter logic [47:0] GEN_SA   = 48'h02AA_BBCC_DDEE,
    parameter logic [15:0] GEN_TYPE = 16'h88B5,
    parameter int unsigned CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clear,
    input  logic             beat,
    input  logic [7:0]       data,
    input  logic             last,
    output logic             frame_err,
    output logic [CNT_W-1:0] err_count
);
    import eth_pe_pkg::*;
    localparam int unsigned FRAME_LEN = HDR_BYTES + PAY_LEN;
    localparam int unsigned PW = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

    logic [PW-1:0]  pos;
    logic           mism, len_bad;
    logic [1:0]     inc;
    logic [CNT_W:0] sum;

    // Per-beat error detection and saturating sum.
    always_comb begin
        mism    = beat && en && (pos < PW'(FRAME_LEN)) &&
                  (data != frame_byte(int'(pos), GEN_SA, GEN_DA, GEN_TYPE));
        len_bad = beat && en && last && (pos != PW'(FRAME_LEN-1));
        inc     = {1'b0, mism} + {1'b0, len_bad};
        sum     = {1'b0, err_count} + {{(CNT_W-1){1'b0}}, inc};
    end

    // Byte position inside the current frame, held at FRAME_LEN beyond it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (beat)
            pos <= last ? '0 : ((pos < PW'(FRAME_LEN)) ? pos + 1'b1 : pos);
    end

    // Error flag and counter, clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            frame_err <= 1'b0;
            err_count <= '0;
        end else begin
            if (mism || len_bad) frame_err <= 1'b1;
            err_count <= (sum > MAXV) ? MAXV[CNT_W-1:0] : sum[CNT_W-1:0];
        end
    end

    a_r5_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> err_count >= $past(err_count));
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (err_count == '0) && !frame_err);
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == MAXV[CNT_W-1:0]) && !clear |=> err_count == MAXV[CNT_W-1:0]);
endmodule

// File: rtl/eth_pe_act.sv
// Activity stretcher: holds its output for ACT_HOLD cycles after each pulse.
module eth_pe_act #(
    parameter int unsigned ACT_HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic active
);
    localparam int unsigned AW = $clog2(ACT_HOLD + 1);
    logic [AW-1:0] cnt;

    // Reload on every frame end, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (pulse)
            cnt <= AW'(ACT_HOLD);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    always_comb active = (cnt != '0);

    a_r10_act_on: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> active);
endmodule

// File: rtl/eth_pattern_engine.sv
// Per-port frame engine: loopback with address swap or pattern source on
// transmit, plus a pattern checker and activity stretcher on receive.
// Assumes gen_en is changed only while rst_n is low.
module eth_pattern_engine #(
    parameter int unsigned PAY_LEN  = 18,
    parameter logic [47:0] GEN_DA   = 48'h0211_2233_4455,
    parameter logic [47:0] GEN_SA   = 48'h02AA_BBCC_DDEE,
    parameter logic [15:0] GEN_TYPE = 16'h88B5,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned ACT_HOLD = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             chk_en,
    input  logic             err_clear,
    input  logic [7:0]       rx_tdata,
    input  logic             rx_tvalid,
    input  logic             rx_tlast,
    output logic             rx_tready,
    output logic [7:0]       tx_tdata,
    output logic             tx_tvalid,
    output logic             tx_tlast,
    input  logic             tx_tready,
    output logic             frame_err,
    output logic [CNT_W-1:0] err_count,
    output logic             activity
);
    logic       g_valid, g_last;
    logic [7:0] g_data;
    logic       s_rx_ready, s_valid, s_last;
    logic [7:0] s_data;
    logic       rx_beat, frame_end;

    eth_pe_gen #(.PAY_LEN(PAY_LEN), .GEN_DA(GEN_DA), .GEN_SA(GEN_SA),
                 .GEN_TYPE(GEN_TYPE)) gen_i (
        .clk(clk), .rst_n(rst_n), .en(gen_en), .tready(tx_tready),
        .tvalid(g_valid), .tdata(g_data), .tlast(g_last));

    eth_pe_swap swap_i (
        .clk(clk), .rst_n(rst_n), .en(!gen_en),
        .rx_tdata(rx_tdata), .rx_tvalid(rx_tvalid), .rx_tlast(rx_tlast),
        .rx_tready(s_rx_ready), .tx_tdata(s_data), .tx_tvalid(s_valid),
        .tx_tlast(s_last), .tx_tready(tx_tready));

    // Transmit source selection and receive readiness per mode.
    always_comb begin
        if (gen_en) begin
            tx_tvalid = g_valid;
            tx_tdata  = g_data;
            tx_tlast  = g_last;
            rx_tready = 1'b1;
        end else begin
            tx_tvalid = s_valid;
            tx_tdata  = s_data;
            tx_tlast  = s_last;
            rx_tready = s_rx_ready;
        end
        rx_beat   = rx_tvalid && rx_tready;
        frame_end = (rx_beat && rx_tlast) || (tx_tvalid && tx_tready && tx_tlast);
    end

    eth_pe_check #(.PAY_LEN(PAY_LEN), .GEN_DA(GEN_DA), .GEN_SA(GEN_SA),
                   .GEN_TYPE(GEN_TYPE), .CNT_W(CNT_W)) check_i (
        .clk(clk), .rst_n(rst_n), .en(chk_en), .clear(err_clear),
        .beat(rx_beat), .data(rx_tdata), .last(rx_tlast),
        .frame_err(frame_err), .err_count(err_count));

    eth_pe_act #(.ACT_HOLD(ACT_HOLD)) act_i (
        .clk(clk), .rst_n(rst_n), .pulse(frame_end), .active(activity));

    a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tvalid && !tx_tready |=> tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast));
    a_r4_gen_stream: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en |-> tx_tvalid && rx_tready);
endmodule

// File: tb/eth_pattern_engine_tb_top.sv
// Scoreboard bench: tasks queue expected transmit bytes, a monitor pops
// and compares them; checker and activity results are checked at the ports.
module eth_pattern_engine_tb_top;
    localparam int PAY   = 18;
    localparam int FLEN  = 14 + PAY;
    localparam int HOLD  = 16;
    localparam int CW    = 8;
    localparam logic [47:0] DA = 48'h0211_2233_4455;
    localparam logic [47:0] SA = 48'h02AA_BBCC_DDEE;
    localparam logic [15:0] LT = 16'h88B5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gen_en = 1'b0, chk_en = 1'b0, err_clear = 1'b0;
    logic [7:0] rx_tdata = 8'h00;
    logic rx_tvalid = 1'b0, rx_tlast = 1'b0;
    logic rx_tready;
    logic [7:0] tx_tdata;
    logic tx_tvalid, tx_tlast;
    logic tx_tready = 1'b0;
    logic frame_err, activity;
    logic [CW-1:0] err_count;

    int checks = 0, errors = 0;
    logic [8:0] txq[$];
    logic [7:0] fb[$];
    logic       stall_on = 1'b0;
    logic       gap_watch = 1'b0;
    int         gaps = 0;
    logic [7:0] lfsr = 8'h5B;
    int         txpos = 0;

    always #2.5 clk = ~clk;

    eth_pattern_engine #(.PAY_LEN(PAY), .GEN_DA(DA), .GEN_SA(SA),
                         .GEN_TYPE(LT), .CNT_W(CW), .ACT_HOLD(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .chk_en(chk_en),
        .err_clear(err_clear), .rx_tdata(rx_tdata), .rx_tvalid(rx_tvalid),
        .rx_tlast(rx_tlast), .rx_tready(rx_tready), .tx_tdata(tx_tdata),
        .tx_tvalid(tx_tvalid), .tx_tlast(tx_tlast), .tx_tready(tx_tready),
        .frame_err(frame_err), .err_count(err_count), .activity(activity));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Independent model of the frame layout.
    function automatic logic [7:0] ref_byte(input int i, input logic [47:0] a0, input logic [47:0] a1);
        if (i < 6) return a0[8*(5-i) +: 8];
        if (i < 12) return a1[8*(11-i) +: 8];
        if (i == 12) return LT[15:8];
        if (i == 13) return LT[7:0];
        return 8'(i - 14);
    endfunction

    // Transmit ready: random stalls, only while expected bytes are queued.
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_tready = (txq.size() != 0) && (!stall_on || lfsr[0]);
    end

    // Monitor: compare each accepted transmit byte with the queue head.
    always @(negedge clk) begin
        #1;
        if (gap_watch && !tx_tvalid) gaps++;
        if (tx_tvalid && tx_tready) begin
            if (txq.size() == 0) begin
                check("R11 unexpected byte", {23'd0, tx_tlast, tx_tdata}, 32'h1FF);
            end else begin
                logic [8:0] e;
                e = txq.pop_front();
                check(gen_en ? "R3 generated byte" : "R2 looped byte",
                      {23'd0, tx_tlast, tx_tdata}, {23'd0, e});
            end
        end
    end

    task automatic send_rx();
        for (int i = 0; i < fb.size(); i++) begin
            @(negedge clk);
            rx_tvalid = 1'b1;
            rx_tdata  = fb[i];
            rx_tlast  = (i == fb.size() - 1);
            #1;
            while (!rx_tready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        rx_tvalid = 1'b0;
        rx_tlast  = 1'b0;
    endtask

    task automatic loop_frame(input int n, input int seed);
        fb.delete();
        for (int i = 0; i < n; i++) fb.push_back(8'(i * 7 + seed));
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = (i < 6) ? fb[i+6] : (i < 12) ? fb[i-6] : fb[i];
            txq.push_back({(i == n - 1), b});
        end
        send_rx();
    endtask

    // Frame in checker-expected form, with selected bytes corrupted.
    task automatic chk_frame(input int n, input int bad0, input int bad1, input logic all_bad);
        fb.delete();
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = (i < FLEN) ? ref_byte(i, SA, DA) : 8'hC3;
            if (i == bad0 || i == bad1 || all_bad) b = ~b;
            fb.push_back(b);
        end
        send_rx();
        #1;
    endtask

    task automatic do_reset(input logic g, input logic c);
        @(negedge clk);
        rst_n = 1'b0;
        gen_en = g;
        chk_en = c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic wait_drain();
        while (txq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Reset state in loopback mode.
        do_reset(1'b0, 1'b0);
        check("R8 reset count", err_count, 0);
        check("R8 reset flag", frame_err, 0);
        check("R10 reset activity", activity, 0);
        check("R1 reset tx idle", tx_tvalid, 0);

        // R1 / R2 loopback, with and without stalls, including a 12-byte frame.
        loop_frame(20, 3);
        stall_on = 1'b1;
        loop_frame(12, 90);
        loop_frame(60, 17);
        stall_on = 1'b0;
        loop_frame(13, 200);
        wait_drain();
        check("R1 all looped bytes delivered", txq.size(), 0);

        // R3 / R4 / R11 generator with random backpressure, three frames.
        do_reset(1'b1, 1'b0);
        stall_on = 1'b1;
        gap_watch = 1'b1;
        for (int f = 0; f < 3; f++)
            for (int i = 0; i < FLEN; i++)
                txq.push_back({(i == FLEN - 1), ref_byte(i, DA, SA)});
        wait_drain();
        gap_watch = 1'b0;
        stall_on = 1'b0;
        check("R4 no valid gaps", gaps, 0);
        check("R4 rx ready in generator mode", rx_tready, 1);

        // Checker cases (generator mode, transmit stalled).
        chk_en = 1'b1;
        chk_frame(FLEN, -1, -1, 1'b0);
        check("R5 good frame count", err_count, 0);
        check("R5 good frame flag", frame_err, 0);
        chk_frame(FLEN, 20, -1, 1'b0);
        check("R5 one bad payload byte count", err_count, 1);
        check("R5 one bad byte flag", frame_err, 1);
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0; #1;
        check("R8 clear count", err_count, 0);
        check("R8 clear flag", frame_err, 0);
        chk_frame(FLEN, 3, 13, 1'b0);
        check("R5 two bad header bytes", err_count, 2);
        chk_frame(FLEN - 2, -1, -1, 1'b0);
        check("R6 short frame", err_count, 3);
        chk_frame(FLEN + 3, -1, -1, 1'b0);
        check("R6 long frame", err_count, 4);
        chk_en = 1'b0;
        chk_frame(FLEN, 5, 25, 1'b0);
        check("R7 disabled checker count", err_count, 4);
        chk_en = 1'b1;
        err_clear = 1'b1;
        chk_frame(FLEN, 7, -1, 1'b0);
        @(negedge clk); err_clear = 1'b0; #1;
        check("R8 clear beats error count", err_count, 0);
        check("R8 clear beats error flag", frame_err, 0);
        for (int k = 0; k < 9; k++) chk_frame(FLEN, -1, -1, 1'b1);
        check("R9 saturated", err_count, 255);
        chk_frame(FLEN, -1, -1, 1'b1);
        check("R9 no wrap", err_count, 255);

        // R10 activity window.
        repeat (HOLD + 4) @(negedge clk);
        #1;
        check("R10 idle activity", activity, 0);
        chk_frame(FLEN, -1, -1, 1'b0);
        begin
            int n;
            n = 0;
            while (activity && n < 4 * HOLD) begin
                n++;
                @(negedge clk);
                #1;
            end
            check("R10 activity width", n, HOLD);
        end

        finish_run();
    end
endmodule